// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides which of a handful of interrupt sources the core should service next. Every source has its own enable bit, and a single global enable gates all of them. Each source is built either as an edge type, where a rising edge on its input sets a pending flag that is kept until it is serviced or cleared by software, or as a level type, which has no flag and requests only while its input is high. The source with the lowest index always wins.

When a request is taken, the block drops the global enable, clears the winning source's flag and counts a fixed response latency. It then presents the vector index and holds it until the core acknowledges. A return-from-interrupt pulse from the core turns the global enable back on. From that pulse on, no new request is taken until the core reports that one more instruction has retired. Software reaches the block through a small write port that sets the enables, clears flags and writes the global enable. The pipeline, the stack and the program counter stay in the core and appear here only as handshake pins.

Top module: `irq_vic`

## Requirements
- R1: Among the sources that are requesting and enabled, the one with the lowest index is taken, and its index appears on `vector_idx`.
- R2: A source is taken only when both its enable bit (write address 0, bit i = source i) and the global enable are 1.
- R3: A rising edge on an edge-type input sets that source's pending flag even while the source or the global enable is 0. The flag stays set and is serviced once both enables are 1.
- R4: Taking an edge-type source clears its pending flag, so a single edge is serviced only once.
- R5: A write to address 1 clears the pending flag of every source whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R6: A level-type source requests only while its input is 1. A pulse that ends before the source is allowed is never serviced, and a level that is still high after its service is taken again.
- R7: Taking a request clears the global enable. A `reti_pulse` sets it to 1, and software writes it through address 2, bit 0. Writing 1 inside a handler allows a nested request to be taken.
- R8: After a `reti_pulse`, no request is taken until at least one `instr_retire` pulse has been seen.
- R9: `req_valid` rises exactly `LAT_CYC` clock edges after the edge at which a request is taken. If `core_sleep` is 1 at that edge, the delay is `LAT_CYC + SLEEP_EXTRA` edges.
- R10: While `req_valid` is 1 and `core_ack` is 0, `req_valid` and `vector_idx` hold their values. `req_valid` falls on the edge that samples `core_ack` high.
- R11: Several flags pending together are serviced one per entry, in increasing index order, as each return and retire opens the block again.
- R12: After reset, `req_valid` is 0, `vector_idx` is 0, all enables and the global enable are 0, and no flag is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC | Interrupt condition inputs, one per source |
| core_sleep | input | 1 | Core is sleeping; lengthens the response latency |
| core_ack | input | 1 | Core accepts the presented vector |
| reti_pulse | input | 1 | Core has executed a return from interrupt |
| instr_retire | input | 1 | Core has retired one instruction |
| reg_we | input | 1 | Software register write strobe |
| reg_addr | input | 2 | Write address: 0 enables, 1 flag clear, 2 global enable |
| reg_wdata | input | NUM_SRC | Write data |
| req_valid | output | 1 | A vector is presented to the core |
| vector_idx | output | IDX_W | Index of the presented source |

## Verification
Take the edge that samples the last stimulus, which is a global-enable or enable write, a level input going high, or an `instr_retire` pulse. A request is taken on the next edge, and `req_valid` is due four edges after that, or eight if the core sleeps. The bench therefore counts falling edges from the stimulus and expects the vector on the fifth, or on the ninth when sleeping. A request that must not be taken is given a twelve-cycle window that is long enough to cover any latency. After `core_ack`, the drop of `req_valid` is checked on the very next falling edge. A checker measures the latency of every request with its own counter and watches the hold and return rules cycle by cycle.

// File: rtl/irq_vic_pkg.sv
package irq_vic_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ISSUE = 2'd2
  } vic_state_e;

  localparam logic [1:0] ADDR_EN  = 2'd0;
  localparam logic [1:0] ADDR_CLR = 2'd1;
  localparam logic [1:0] ADDR_GIE = 2'd2;
endpackage

// File: rtl/irq_vic_cfg.sv
module irq_vic_cfg #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] clr_sw,
  output logic               gie_wr,
  output logic               gie_wval
);
  import irq_vic_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (reg_we && reg_addr == ADDR_EN) begin
      en_q <= reg_wdata;
    end
  end

  always_comb begin
    clr_sw   = (reg_we && reg_addr == ADDR_CLR) ? reg_wdata : '0;
    gie_wr   = reg_we && (reg_addr == ADDR_GIE);
    gie_wval = reg_wdata[0];
  end
endmodule

// File: rtl/irq_vic_src.sv
module irq_vic_src #(
  parameter int               NUM_SRC    = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] clr_sw,
  input  logic [NUM_SRC-1:0] clr_hw,
  output logic [NUM_SRC-1:0] req_raw
);
  localparam logic [NUM_SRC-1:0] EDGE_MASK = ~LEVEL_MASK;

  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] rise;

  assign rise = irq_in & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= irq_in;
      // a fresh edge in the same cycle as a clear wins
      pend_q <= ((pend_q & ~(clr_sw | clr_hw)) | rise) & EDGE_MASK;
    end
  end

  assign req_raw = (pend_q & EDGE_MASK) | (irq_in & LEVEL_MASK);
endmodule

// File: rtl/irq_vic_prio.sv
module irq_vic_prio #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vic_seq.sv
module irq_vic_seq #(
  parameter int NUM_SRC     = 8,
  parameter int LAT_CYC     = 4,
  parameter int SLEEP_EXTRA = 4,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int LAT_MX = LAT_CYC + SLEEP_EXTRA,
  localparam int CNT_W  = $clog2(LAT_MX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any_req,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             core_sleep,
  input  logic             core_ack,
  input  logic             reti_pulse,
  input  logic             instr_retire,
  input  logic             gie_wr,
  input  logic             gie_wval,
  output logic             take,
  output logic             gie_q,
  output logic             req_valid,
  output logic [IDX_W-1:0] vector_idx
);
  import irq_vic_pkg::*;

  vic_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  assign take = (state_q == ST_IDLE) && gie_q && armed_q && any_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q   <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      if (take)            gie_q <= 1'b0;
      else if (reti_pulse) gie_q <= 1'b1;
      else if (gie_wr)     gie_q <= gie_wval;

      if (reti_pulse)        armed_q <= 1'b0;
      else if (instr_retire) armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      req_valid  <= 1'b0;
      vector_idx <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (take) begin
            state_q    <= ST_WAIT;
            vector_idx <= win_idx;
            cnt_q      <= core_sleep ? CNT_W'(LAT_MX - 1) : CNT_W'(LAT_CYC - 1);
          end
        end
        ST_WAIT: begin
          if (cnt_q == '0) begin
            state_q   <= ST_ISSUE;
            req_valid <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_ISSUE: begin
          if (core_ack) begin
            state_q   <= ST_IDLE;
            req_valid <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_vic.sv
module irq_vic #(
  parameter int                 NUM_SRC     = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK  = 8'hC0,
  parameter int                 LAT_CYC     = 4,
  parameter int                 SLEEP_EXTRA = 4,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               core_sleep,
  input  logic               core_ack,
  input  logic               reti_pulse,
  input  logic               instr_retire,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic               req_valid,
  output logic [IDX_W-1:0]   vector_idx
);
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] clr_sw;
  logic [NUM_SRC-1:0] clr_hw;
  logic [NUM_SRC-1:0] req_raw;
  logic               gie_wr;
  logic               gie_wval;
  logic               any_req;
  logic [IDX_W-1:0]   win_idx;
  logic               take;
  logic               gie_q;

  irq_vic_cfg #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .en_q(en_q), .clr_sw(clr_sw),
    .gie_wr(gie_wr), .gie_wval(gie_wval)
  );

  irq_vic_src #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) u_src (
    .clk(clk), .rst(rst), .irq_in(irq_in), .clr_sw(clr_sw),
    .clr_hw(clr_hw), .req_raw(req_raw)
  );

  irq_vic_prio #(.NUM_SRC(NUM_SRC)) u_prio (
    .req(req_raw & en_q), .any(any_req), .idx(win_idx)
  );

  irq_vic_seq #(.NUM_SRC(NUM_SRC), .LAT_CYC(LAT_CYC), .SLEEP_EXTRA(SLEEP_EXTRA)) u_seq (
    .clk(clk), .rst(rst), .any_req(any_req), .win_idx(win_idx),
    .core_sleep(core_sleep), .core_ack(core_ack), .reti_pulse(reti_pulse),
    .instr_retire(instr_retire), .gie_wr(gie_wr), .gie_wval(gie_wval),
    .take(take), .gie_q(gie_q), .req_valid(req_valid), .vector_idx(vector_idx)
  );

  assign clr_hw = take ? (NUM_SRC'(1) << win_idx) : '0;
endmodule

// File: rtl/irq_vic_chk.sv
module irq_vic_chk #(
  parameter int NUM_SRC     = 8,
  parameter int LAT_CYC     = 4,
  parameter int SLEEP_EXTRA = 4,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [IDX_W-1:0] vector_idx,
  input logic             core_ack,
  input logic             core_sleep,
  input logic             reti_pulse,
  input logic             instr_retire,
  input logic             take,
  input logic             gie_q
);
  logic        reti_open;
  logic [15:0] lat_cnt;
  logic [15:0] lat_exp;

  always_ff @(posedge clk) begin
    if (rst) begin
      reti_open <= 1'b0;
      lat_cnt   <= '0;
      lat_exp   <= '0;
    end else begin
      if (reti_pulse)        reti_open <= 1'b1;
      else if (instr_retire) reti_open <= 1'b0;

      if (take) begin
        lat_cnt <= 16'd1;
        lat_exp <= 16'(LAT_CYC + 1 + (core_sleep ? SLEEP_EXTRA : 0));
      end else if (lat_cnt != '0 && !req_valid) begin
        lat_cnt <= lat_cnt + 16'd1;
      end
    end
  end

  // R10
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !core_ack) |=> (req_valid && $stable(vector_idx)));

  // R10
  drop_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && core_ack) |=> !req_valid);

  // R7
  gie_off_on_entry_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> !gie_q);

  // R8
  retire_after_reti_chk: assert property (@(posedge clk) disable iff (rst)
    reti_open |-> !take);

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) |-> (lat_cnt == lat_exp));
endmodule

bind irq_vic irq_vic_chk #(
  .NUM_SRC(NUM_SRC), .LAT_CYC(LAT_CYC), .SLEEP_EXTRA(SLEEP_EXTRA)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .vector_idx(vector_idx),
  .core_ack(core_ack), .core_sleep(core_sleep), .reti_pulse(reti_pulse),
  .instr_retire(instr_retire), .take(take), .gie_q(gie_q)
);

// File: tb/irq_vic_tb.sv
`timescale 1ns/1ps
module irq_vic_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] irq_in = '0;
  logic         core_sleep = 1'b0;
  logic         core_ack = 1'b0;
  logic         reti_pulse = 1'b0;
  logic         instr_retire = 1'b0;
  logic         reg_we = 1'b0;
  logic [1:0]   reg_addr = '0;
  logic [N-1:0] reg_wdata = '0;
  logic         req_valid;
  logic [1:0]   vector_idx;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  irq_vic #(.NUM_SRC(N), .LEVEL_MASK(4'b1000), .LAT_CYC(4), .SLEEP_EXTRA(4)) u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .core_sleep(core_sleep),
    .core_ack(core_ack), .reti_pulse(reti_pulse), .instr_retire(instr_retire),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .req_valid(req_valid), .vector_idx(vector_idx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk);
    irq_in = irq_in | m;
    @(negedge clk);
    irq_in = irq_in & ~m;
  endtask

  // falling edges from now until req_valid is seen (0 = never within limit)
  task automatic wait_req(input int limit, output int n);
    n = 0;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (req_valid) begin
        n = k;
        break;
      end
    end
  endtask

  task automatic ack();
    @(negedge clk); core_ack = 1'b1;
    @(negedge clk); core_ack = 1'b0;
    chk(req_valid == 1'b0, "R10 req_valid drop after ack", req_valid, 0);
  endtask

  task automatic reti();
    @(negedge clk); reti_pulse = 1'b1;
    @(negedge clk); reti_pulse = 1'b0;
  endtask

  task automatic retire();
    @(negedge clk); instr_retire = 1'b1;
    @(negedge clk); instr_retire = 1'b0;
  endtask

  task automatic expect_vec(input string tag, input int lat, input int idx);
    int n;
    wait_req(12, n);
    chk(n == lat, {tag, " latency"}, n, lat);
    chk(int'(vector_idx) == idx, {tag, " vector"}, vector_idx, idx);
  endtask

  task automatic expect_none(input string tag);
    int n;
    wait_req(12, n);
    chk(n == 0, {tag, " no request"}, n, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk(req_valid == 1'b0, "R12 req_valid after reset", req_valid, 0);
    chk(vector_idx == 2'd0, "R12 vector_idx after reset", vector_idx, 0);
    pulse(4'b0111);
    expect_none("R12 nothing enabled after reset");
    wr(2'd1, 4'hF);

    // R1 sweep: every enable mask against every request pattern
    for (int e = 0; e < 16; e++) begin
      for (int p = 0; p < 16; p++) begin
        int win;
        int n;
        wr(2'd2, 4'h0);
        wr(2'd0, 4'(e));
        wr(2'd1, 4'hF);
        @(negedge clk);
        irq_in[3] = p[3];
        pulse(4'(p) & 4'b0111);
        wr(2'd2, 4'h1);
        win = -1;
        for (int b = N - 1; b >= 0; b--)
          if (e[b] && p[b]) win = b;
        wait_req(12, n);
        if (win < 0) begin
          chk(n == 0, "R1 sweep no winner", n, 0);
        end else begin
          chk(n == 5 && int'(vector_idx) == win, "R1 sweep winner (lat*10+idx)",
              n * 10 + vector_idx, 50 + win);
        end
        if (n != 0) ack();
        wr(2'd2, 4'h0);
        @(negedge clk);
        irq_in = '0;
        wr(2'd1, 4'hF);
      end
    end

    // R2 / R3: flag survives while the source is masked
    wr(2'd0, 4'b0000);
    pulse(4'b0001);
    wr(2'd2, 4'h1);
    expect_none("R2 masked source");
    wr(2'd0, 4'b0001);
    expect_vec("R3 pending survives mask", 5, 0);
    ack();

    // R7: global enable cleared on entry, software set allows nesting
    wr(2'd0, 4'b0011);
    pulse(4'b0010);
    expect_none("R7 gie cleared on entry");
    wr(2'd2, 4'h1);
    expect_vec("R7 software nesting", 5, 1);
    ack();

    // R8: return needs one retired instruction
    reti();
    wr(2'd0, 4'b0111);
    pulse(4'b0100);
    expect_none("R8 blocked before retire");
    retire();
    expect_vec("R8 taken after retire", 5, 2);
    ack();

    // R11 / R4: three flags served in order, once each
    reti();
    pulse(4'b0111);
    retire();
    expect_vec("R11 first", 5, 0);
    ack(); reti(); retire();
    expect_vec("R11 second", 5, 1);
    ack(); reti(); retire();
    expect_vec("R11 third", 5, 2);
    ack(); reti(); retire();
    expect_none("R4 flags cleared by service");

    // R9: sleeping core adds latency
    core_sleep = 1'b1;
    wr(2'd2, 4'h0);
    pulse(4'b0010);
    wr(2'd2, 4'h1);
    expect_vec("R9 sleep latency", 9, 1);
    core_sleep = 1'b0;
    ack();

    // R10: vector held while waiting for ack, even with a higher source pending
    pulse(4'b0100);
    wr(2'd2, 4'h1);
    expect_vec("R10 setup", 5, 2);
    pulse(4'b0001);
    begin
      bit held = 1'b1;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (!req_valid || vector_idx != 2'd2) held = 1'b0;
      end
      chk(held, "R10 hold until ack", held, 1);
    end
    ack();
    wr(2'd1, 4'b0001);

    // R5: zero bits leave flags alone, one bits clear
    pulse(4'b0010);
    wr(2'd1, 4'b1101);
    wr(2'd2, 4'h1);
    expect_vec("R5 zero bit keeps flag", 5, 1);
    ack();
    pulse(4'b0010);
    wr(2'd1, 4'b0010);
    wr(2'd2, 4'h1);
    expect_none("R5 one bit clears flag");

    // R6: level source
    wr(2'd2, 4'h0);
    wr(2'd0, 4'hF);
    pulse(4'b1000);
    wr(2'd2, 4'h1);
    expect_none("R6 vanished level");
    @(negedge clk);
    irq_in[3] = 1'b1;
    expect_vec("R6 level taken", 5, 3);
    ack(); reti(); retire();
    expect_vec("R6 level retaken", 5, 3);
    ack();
    @(negedge clk);
    irq_in[3] = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule